// File: doc/BRIEF.md
# Zero-Run Frame Phase Resynchronizer

This block sits in the digital datapath of an audio DAC. It keeps a free-running frame-phase counter that advances once per master-clock cycle and spans 256 cycles per sample period. It watches the left and right sample streams for long runs of zero-valued samples. When both channels have been silent long enough, or when software raises a soft-resync request, it checks the counter against the selected edge of the external frame clock. If the counter has drifted further than the tolerance, the block snaps the counter back into line with that edge.

A realignment can cause a small disturbance downstream. To cover it, the block blanks its sample output to zero for a short hold interval after every realignment it performs. When the counter is already in line, no realignment takes place and the output is not blanked. Samples enter and leave through valid/ready streams with a single register stage. The frame clock is expected to be generated in the master-clock domain.

Top module: `zr_resync`

## Requirements
- R1: Each channel has a zero flag. It rises in the cycle after that channel's RUN_LEN-th (default 8192) consecutive accepted sample whose value is zero. It stays high while further accepted samples on that channel are zero.
- R2: An accepted nonzero sample on a channel clears that channel's run count and zero flag at the next cycle. The run count saturates at RUN_LEN instead of wrapping.
- R3: After reset the frame phase reads 0. It then advances by one every master-clock cycle and wraps from PERIOD-1 (default 255) to 0.
- R4: The edge that is compared against the counter depends on two inputs. With ext_filter=0 and alt_format=0 it is the falling edge of frame_clk. With ext_filter=0 and alt_format=1 it is the rising edge. With ext_filter=1 it is the falling edge, whatever the value of alt_format. The other edge never causes a realignment.
- R5: A resync trigger exists while resync_en=1 and either both zero flags are high or soft_req=1. A zero flag on only one channel is not a trigger.
- R6: Take P as the phase value in the cycle where the selected edge is seen. The circular distance of P from 0 is min(P, PERIOD-P). At a selected edge under a trigger, the block realigns only if that distance exceeds TOL (default 3). A realignment makes the phase read 1 in the next cycle. Otherwise the phase reads P+1.
- R7: After a realignment, the next HOLD (default 5) accepted samples leave as zero on both channels. The samples after those pass through unchanged. When no realignment takes place, no samples are blanked.
- R8: While the hold is still counting, no further realignment takes place, even under a trigger at a misaligned edge.
- R9: With resync_en=0 no realignment takes place.
- R10: A sample is accepted when in_valid and in_ready are both high. in_ready equals !out_valid | out_ready. While out_valid=1 and out_ready=0, out_valid, out_left and out_right hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | External frame clock (frame or word clock), master-clock domain |
| resync_en | input | 1 | Allows realignment |
| soft_req | input | 1 | Soft resync request (level) |
| ext_filter | input | 1 | 1 selects external-filter mode |
| alt_format | input | 1 | 1 selects the rising-edge frame format in standard mode |
| in_valid | input | 1 | Input sample pair valid |
| in_ready | output | 1 | Input sample pair can be accepted |
| in_left | input | DW | Left input sample |
| in_right | input | DW | Right input sample |
| out_valid | output | 1 | Output sample pair valid |
| out_ready | input | 1 | Downstream accepts output pair |
| out_left | output | DW | Left output sample (gated) |
| out_right | output | DW | Right output sample (gated) |
| zero_left | output | 1 | Left zero-run flag |
| zero_right | output | 1 | Right zero-run flag |
| frame_phase | output | $clog2(PERIOD) | Internal frame-phase counter |

## Verification
Each result becomes valid at a known cycle, and the bench reads it there:
- A zero flag is due one cycle after the accepted sample that completes the run.
- The phase realigns in the cycle after the edge is seen.
- An accepted sample appears at the output one cycle after it is accepted.

The bench drives inputs on the falling clock edge and moves the frame clock a quarter period after the rising edge. It reads the phase on the falling edge just before the design samples the frame edge, which gives P. One falling edge later it reads the phase again and compares it with 1 or P+1. Hold blanking is checked one sample per cycle over the HOLD+2 samples that follow a realignment. Zero flags are checked after RUN_LEN-1 and after RUN_LEN accepted zeros.

// File: rtl/zr_pkg.sv
package zr_pkg;

  // circular distance of a phase value from zero on a ring of 'period' steps
  function automatic int unsigned ring_dist(input int unsigned p, input int unsigned period);
    return (p > period / 2) ? (period - p) : p;
  endfunction

endpackage

// File: rtl/zr_zero_run.sv
module zr_zero_run #(
  parameter int unsigned DW      = 32,
  parameter int unsigned RUN_LEN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] sample,
  output logic          run_done
);

  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (accept) begin
      if (sample != '0) begin
        run_cnt <= '0;
      end else if (run_cnt != RUN_MAX) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign run_done = (run_cnt == RUN_MAX);

  // R2: a nonzero accepted sample drops the flag
  assert_nonzero_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sample != '0) |=> !run_done)
    else $error("nonzero sample left zero flag set");

  // R2: count never passes the saturation limit
  assert_run_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_MAX)
    else $error("zero run count overflowed");

  // R1: flag holds while zeros keep arriving or nothing is accepted
  assert_flag_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && (!accept || sample == '0)) |=> run_done)
    else $error("zero flag dropped without a nonzero sample");

endmodule

// File: rtl/zr_phase_align.sv
module zr_phase_align #(
  parameter int unsigned PERIOD = 256,
  parameter int unsigned TOL    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_clk,
  input  logic                      use_rise,
  input  logic                      trig,
  output logic [$clog2(PERIOD)-1:0] phase,
  output logic                      realign
);

  import zr_pkg::*;

  localparam int unsigned PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic frame_q;
  logic rise_seen, fall_seen, edge_hit, off_sync;

  // previous frame clock level; no reset so the first edge after reset is real
  always_ff @(posedge clk) begin
    frame_q <= frame_clk;
  end

  assign rise_seen = frame_clk & ~frame_q;
  assign fall_seen = ~frame_clk & frame_q;
  assign edge_hit  = use_rise ? rise_seen : fall_seen;
  assign off_sync  = ring_dist(int'(phase), PERIOD) > TOL;
  assign realign   = edge_hit & trig & off_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (realign) begin
      phase <= PW'(1);
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // R3: phase stays inside one frame
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < PERIOD)
    else $error("phase out of range");

  // R3: phase steps by one when not realigned
  assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!realign && phase != LAST) |=> (phase == $past(phase) + 1'b1))
    else $error("phase did not advance");

  // R6: realignment places the counter one step past the edge
  assert_realign_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (phase == PW'(1)))
    else $error("realign did not land on phase 1");

endmodule

// File: rtl/zr_hold_gate.sv
module zr_hold_gate #(
  parameter int unsigned DW   = 32,
  parameter int unsigned HOLD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          realign,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          in_fire,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right,
  output logic          busy
);

  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD);

  logic [HW-1:0] hold_cnt;

  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;
  assign busy     = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (realign) begin
      hold_cnt <= HOLD_LOAD;
    end else if (in_fire && busy) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_left  <= busy ? '0 : in_left;
      out_right <= busy ? '0 : in_right;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a realignment arms the full hold
  assert_hold_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (hold_cnt == HOLD_LOAD))
    else $error("hold not armed after realign");

  // R7: samples taken during the hold leave as zero
  assert_hold_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && busy) |=> (out_left == '0 && out_right == '0))
    else $error("sample passed during hold");

  // R10: stalled output is held steady
  assert_stall_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)))
    else $error("output changed under back-pressure");

endmodule

// File: rtl/zr_resync.sv
module zr_resync #(
  parameter int unsigned DW      = 32,
  parameter int unsigned RUN_LEN = 8192,
  parameter int unsigned PERIOD  = 256,
  parameter int unsigned TOL     = 3,
  parameter int unsigned HOLD    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_clk,
  input  logic                      resync_en,
  input  logic                      soft_req,
  input  logic                      ext_filter,
  input  logic                      alt_format,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DW-1:0]             in_left,
  input  logic [DW-1:0]             in_right,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DW-1:0]             out_left,
  output logic [DW-1:0]             out_right,
  output logic                      zero_left,
  output logic                      zero_right,
  output logic [$clog2(PERIOD)-1:0] frame_phase
);

  localparam int unsigned LANES = 2;

  logic [DW-1:0]    lane_data [LANES];
  logic [LANES-1:0] lane_zero;
  logic             in_fire, busy, realign, trig, use_rise;

  assign lane_data[0] = in_left;
  assign lane_data[1] = in_right;

  for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
    zr_zero_run #(.DW(DW), .RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (in_fire),
      .sample   (lane_data[ch]),
      .run_done (lane_zero[ch])
    );
  end

  assign zero_left  = lane_zero[0];
  assign zero_right = lane_zero[1];

  assign use_rise = ~ext_filter & alt_format;
  assign trig     = resync_en & ((&lane_zero) | soft_req) & ~busy;

  zr_phase_align #(.PERIOD(PERIOD), .TOL(TOL)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_clk (frame_clk),
    .use_rise  (use_rise),
    .trig      (trig),
    .phase     (frame_phase),
    .realign   (realign)
  );

  zr_hold_gate #(.DW(DW), .HOLD(HOLD)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .realign   (realign),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_fire   (in_fire),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_left  (out_left),
    .out_right (out_right),
    .busy      (busy)
  );

  // R5: a realignment always has a cause at the ports
  assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> ((zero_left && zero_right) || soft_req))
    else $error("realign without joint zero run or soft request");

  // R9: disabled block never realigns
  assert_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_en |-> !realign)
    else $error("realign while disabled");

  // R8: no realignment during an active hold
  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !realign)
    else $error("realign during hold");

  // R4: realignment only on the edge the mode selects
  assert_edge_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> ((ext_filter || !alt_format) ? $fell(frame_clk) : $rose(frame_clk)))
    else $error("realign on wrong frame edge");

endmodule

// File: tb/zr_resync_test.sv
module zr_resync_test;

  localparam int DW  = 32;
  localparam int RUN = 8192;
  localparam int PER = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          frame_clk = 1'b1;
  logic          resync_en = 1'b0, soft_req = 1'b0, ext_filter = 1'b0, alt_format = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic          in_ready, out_valid, zero_left, zero_right;
  logic [DW-1:0] out_left, out_right;
  logic [7:0]    frame_phase;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int off    = 1000;

  zr_resync uut (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .resync_en(resync_en),
    .soft_req(soft_req), .ext_filter(ext_filter), .alt_format(alt_format),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .zero_left(zero_left), .zero_right(zero_right), .frame_phase(frame_phase)
  );

  // frame clock: 256-cycle period, updated a quarter period after the rising edge
  always @(posedge clk) begin
    #5;
    cyc++;
    frame_clk = (((cyc + off) % PER) < 128);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // delay the next frame edges by k cycles (done in the high half, no edge produced)
  task automatic shift(input int k);
    do @(negedge clk); while (((cyc + off) % PER) != 50);
    off -= k;
  endtask

  // wait for an edge, read phase P before it is taken, then the phase after it
  task automatic edge_check(input bit rise, input bit trig, input string tag, output int p);
    bit prev;
    int q, d, expv;
    prev = frame_clk;
    forever begin
      @(negedge clk);
      if (frame_clk != prev && frame_clk == rise) break;
      prev = frame_clk;
    end
    p = int'(frame_phase);
    @(negedge clk);
    q = int'(frame_phase);
    d = (p > PER / 2) ? PER - p : p;
    expv = (trig && d > 3) ? 1 : (p + 1) % PER;
    chk(q == expv, tag, q, expv);
  endtask

  task automatic run_zeros(input bit both, input string tag);
    in_left  = '0;
    in_right = both ? '0 : 32'd5;
    repeat (RUN - 1) @(negedge clk);
    chk(zero_left == 1'b0, {tag, " left flag before run end"}, zero_left, 0);
    @(negedge clk);
    chk(zero_left == 1'b1, {tag, " left flag at run end"}, zero_left, 1);
    chk(zero_right == both, {tag, " right flag at run end"}, zero_right, both);
  endtask

  task automatic t_reset;
    chk(frame_phase == 8'd0, "R3 phase after reset", frame_phase, 0);
    chk(zero_left == 1'b0 && zero_right == 1'b0, "R1 flags after reset", {zero_left, zero_right}, 0);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    repeat (300) @(negedge clk);
    chk(frame_phase == 8'd44, "R3 phase wraps", frame_phase, 44);
  endtask

  task automatic t_one_side;
    int p;
    run_zeros(1'b0, "R1");
    edge_check(1'b0, 1'b0, "R5 single channel no realign", p);
    repeat (50) @(negedge clk);
    chk(zero_left == 1'b1, "R2 flag saturates", zero_left, 1);
    in_left = 32'd7;
    @(negedge clk);
    chk(zero_left == 1'b0, "R2 nonzero clears flag", zero_left, 0);
  endtask

  task automatic t_soft;
    int p;
    soft_req = 1'b1;
    edge_check(1'b0, 1'b1, "R5 soft request", p);
    soft_req = 1'b0;
  endtask

  task automatic t_joint_mis;
    int p;
    shift(40);
    run_zeros(1'b1, "R1 joint");
    edge_check(1'b0, 1'b1, "R6 joint misaligned realign", p);
    chk(p == 40, "R6 edge phase before realign", p, 40);
    for (int i = 1; i <= 7; i++) begin
      in_left  = DW'(i);
      in_right = DW'(i + 100);
      @(negedge clk);
      chk(out_left == ((i <= 5) ? 0 : i), "R7 hold left", out_left, (i <= 5) ? 0 : i);
      chk(out_right == ((i <= 5) ? 0 : i + 100), "R7 hold right", out_right, (i <= 5) ? 0 : i + 100);
    end
  endtask

  task automatic t_joint_aligned;
    int p;
    shift(2);
    run_zeros(1'b1, "R1 joint");
    edge_check(1'b0, 1'b1, "R6 aligned no realign", p);
    chk(p == 2, "R6 aligned edge phase", p, 2);
    in_left  = 32'd9;
    in_right = 32'd10;
    @(negedge clk);
    chk(out_left == 32'd9, "R7 no hold when aligned", out_left, 9);
    soft_req = 1'b1;
    shift(1);
    edge_check(1'b0, 1'b1, "R6 tolerance 3 kept", p);
    chk(p == 3, "R6 edge phase 3", p, 3);
    shift(1);
    edge_check(1'b0, 1'b1, "R6 tolerance 4 realigns", p);
    chk(p == 4, "R6 edge phase 4", p, 4);
    soft_req = 1'b0;
  endtask

  task automatic t_hold_block;
    int p;
    soft_req = 1'b1;
    shift(20);
    edge_check(1'b0, 1'b1, "R8 arming realign", p);
    in_valid = 1'b0;
    shift(30);
    edge_check(1'b0, 1'b0, "R8 no realign during hold", p);
    chk(p == 30, "R8 edge phase during hold", p, 30);
    in_valid = 1'b1;
    repeat (5) @(negedge clk);
    edge_check(1'b0, 1'b1, "R8 realign after hold", p);
  endtask

  task automatic t_enable;
    int p;
    resync_en = 1'b0;
    shift(50);
    edge_check(1'b0, 1'b0, "R9 disabled no realign", p);
    chk(p == 50, "R9 edge phase", p, 50);
  endtask

  task automatic t_polarity;
    int p;
    resync_en  = 1'b1;
    alt_format = 1'b1;
    edge_check(1'b1, 1'b1, "R4 rising edge in alt format", p);
    edge_check(1'b0, 1'b0, "R4 falling edge ignored in alt format", p);
    chk(p == 128, "R4 falling edge phase", p, 128);
    ext_filter = 1'b1;
    edge_check(1'b0, 1'b1, "R4 ext mode falling edge", p);
    chk(p == 128, "R4 ext mode edge phase", p, 128);
    soft_req   = 1'b0;
    ext_filter = 1'b0;
    alt_format = 1'b0;
  endtask

  task automatic t_stall;
    repeat (10) @(negedge clk);
    in_left  = 32'd11;
    in_right = 32'd12;
    @(negedge clk);
    chk(out_left == 32'd11 && out_valid, "R10 pass-through", out_left, 11);
    out_ready = 1'b0;
    in_left   = 32'd13;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 in_ready low under stall", in_ready, 0);
    @(negedge clk);
    chk(out_left == 32'd11 && out_valid, "R10 stalled output held", out_left, 11);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_left == 32'd13, "R10 resumes after stall", out_left, 13);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        in_valid  = 1'b1;
        in_left   = 32'd5;
        in_right  = 32'd5;
        resync_en = 1'b1;
        t_one_side();
        t_soft();
        t_joint_mis();
        t_joint_aligned();
        t_hold_block();
        t_enable();
        t_polarity();
        t_stall();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule